// File: doc/BRIEF.md
# Mailbox Message Requester with Timeout

This block issues one command at a time to a management microcontroller through a small register window. The window has three words: a message word, an argument word and a response word. A request carries a message identifier. It may also carry a 32-bit argument, and it may ask for a result word to be fetched back. The block performs the register writes in a fixed order and then polls the response word, at most once per microsecond tick. Polling stops when the response is nonzero or when a per-request poll budget runs out. The block then reads the response one final time and classifies it.

The register window is reached through a plain master port. Writes take one cycle. A read returns its data on `bus_rdata` in the cycle after `bus_rd`. Word addresses are 0 for the message word, 1 for the argument word and 2 for the response word. A caller raises `req_valid` while `busy` is low. It then waits for the single-cycle `done` pulse and reads the classification outputs, which stay valid until the next request is accepted.

Top module: `mbx_requester`

## Requirements
- R1: While reset is held and in the cycle after it is released, `busy`, `done`, `bus_wr`, `bus_rd`, `ok`, `err_inval` and `timed_out` are all 0. A reset in the middle of a request abandons it and stops all register access.
- R2: When `req_has_arg` is 1, the argument word (address 1) is written with `req_arg` exactly once, in the cycle just before the message write. When `req_has_arg` is 0, the argument word is not written.
- R3: The message word (address 0) is written exactly once per request. The write data is the low 16 bits of `req_msg`, zero-extended to 32 bits.
- R4: The response word (address 2) is polled by reads whose low 8 bits form the response code. The first poll directly follows the message write. Each further poll needs a `tick_us` pulse, and polling ends at the first nonzero code.
- R5: If `timeout_limit` polls all return a zero code, polling stops. A limit of 0 means no polls. In either case exactly one final read of the response word follows, so the word is read `timeout_limit`+1 times in total.
- R6: The final code is reported on `resp_code`. Code 0x01 sets `ok`. Codes 0xFE and 0xFF set `err_inval`. Any other nonzero code sets neither flag. Bits above the low 8 are ignored.
- R7: `timed_out` is 1 exactly when the final code is 0, and then `ok` and `err_inval` are 0.
- R8: When `req_fetch` is 1 and the result is `ok`, the argument word is read once after the final read, and `result` takes its value. Otherwise the argument word is never read, and `result` is 0.
- R9: `busy` is 1 from the cycle after acceptance until `done`. `done` is high for exactly one cycle per request. A `req_valid` raised while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_msg | input | 32 | Message identifier, masked to 16 bits |
| req_has_arg | input | 1 | Write the argument word first |
| req_arg | input | 32 | Argument value |
| req_fetch | input | 1 | Read the argument word back after success |
| timeout_limit | input | 16 | Poll budget for this request |
| tick_us | input | 1 | One-microsecond pacing pulse |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Final code was 0x01 |
| err_inval | output | 1 | Final code was 0xFE or 0xFF |
| timed_out | output | 1 | Final code was 0 |
| resp_code | output | 8 | Final response code |
| result | output | 32 | Fetched result word |
| bus_wr | output | 1 | Register write strobe |
| bus_rd | output | 1 | Register read strobe |
| bus_addr | output | 2 | Register word address |
| bus_wdata | output | 32 | Register write data |
| bus_rdata | input | 32 | Register read data, one cycle after bus_rd |

## Verification
Requests are run with and without an argument and with and without a fetch. Each run checks the write order and that a dropped argument write is really absent. The emulated controller answers with 0x01, 0xFE, 0xFF, an unclassified code, and a success code with junk in the upper bits. These separate the three result classes and expose any missing mask. A long-delayed answer against a budget of 4 polls, and a budget of 0, separate a true timeout from success and pin down the exact read count. A request raised while busy, and a reset in the middle of polling, show that extra stimulus and aborted work leave no trace on the bus.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADR_MSG  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_ARG  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_RESP = 2'd2;

    typedef enum logic [3:0] {
        S_IDLE, S_WR_ARG, S_WR_MSG, S_POLL_WAIT, S_POLL_RD, S_POLL_CHK,
        S_FIN_RD, S_FIN_CHK, S_FET_RD, S_FET_CHK, S_DONE
    } mbx_state_e;
endpackage

// File: rtl/mbx_poll_count.sv
module mbx_poll_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (step) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // This poll uses up the budget once the count after it reaches the limit.
    assign last = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit};

    // The counter never steps beyond the poll budget.
    AST_POLL_WITHIN_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (cnt_q < limit)); // R5
endmodule

// File: rtl/mbx_resp_decode.sv
module mbx_resp_decode #(
    parameter int RESP_W = 8
) (
    input  logic [RESP_W-1:0] code,
    output logic              is_zero,
    output logic              is_ok,
    output logic              is_inval
);
    localparam logic [RESP_W-1:0] CODE_OK   = RESP_W'(8'h01);
    localparam logic [RESP_W-1:0] CODE_BAD0 = RESP_W'(8'hFE);
    localparam logic [RESP_W-1:0] CODE_BAD1 = RESP_W'(8'hFF);

    always_comb begin
        is_zero  = (code == '0);
        is_ok    = (code == CODE_OK);
        is_inval = (code == CODE_BAD0) || (code == CODE_BAD1);
    end
endmodule

// File: rtl/mbx_requester.sv
module mbx_requester
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MSG_W  = 16,
    parameter int RESP_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] req_msg,
    input  logic              req_has_arg,
    input  logic [DATA_W-1:0] req_arg,
    input  logic              req_fetch,
    input  logic [CNT_W-1:0]  timeout_limit,
    input  logic              tick_us,
    output logic              busy,
    output logic              done,
    output logic              ok,
    output logic              err_inval,
    output logic              timed_out,
    output logic [RESP_W-1:0] resp_code,
    output logic [DATA_W-1:0] result,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);
    typedef struct packed {
        mbx_state_e        st;
        logic [MSG_W-1:0]  msg;
        logic [DATA_W-1:0] arg;
        logic              has_arg;
        logic              fetch;
        logic [CNT_W-1:0]  limit;
        logic              ok;
        logic              inval;
        logic              to;
        logic [RESP_W-1:0] code;
        logic [DATA_W-1:0] result;
    } regs_t;

    regs_t r_d, r_q;
    logic  cnt_clr, cnt_step, cnt_last;
    logic  dec_zero, dec_ok, dec_inval;

    mbx_poll_count #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .step  (cnt_step),
        .limit (r_q.limit),
        .last  (cnt_last)
    );

    mbx_resp_decode #(.RESP_W(RESP_W)) u_dec (
        .code     (bus_rdata[RESP_W-1:0]),
        .is_zero  (dec_zero),
        .is_ok    (dec_ok),
        .is_inval (dec_inval)
    );

    always_comb begin
        r_d       = r_q;
        cnt_clr   = 1'b0;
        cnt_step  = 1'b0;
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
        bus_addr  = ADR_MSG;
        bus_wdata = '0;
        unique case (r_q.st)
            S_IDLE: begin
                cnt_clr = 1'b1;
                if (req_valid) begin
                    r_d.msg     = req_msg[MSG_W-1:0];
                    r_d.arg     = req_arg;
                    r_d.has_arg = req_has_arg;
                    r_d.fetch   = req_fetch;
                    r_d.limit   = timeout_limit;
                    r_d.ok      = 1'b0;
                    r_d.inval   = 1'b0;
                    r_d.to      = 1'b0;
                    r_d.code    = '0;
                    r_d.result  = '0;
                    r_d.st      = req_has_arg ? S_WR_ARG : S_WR_MSG;
                end
            end
            S_WR_ARG: begin
                bus_wr    = 1'b1;
                bus_addr  = ADR_ARG;
                bus_wdata = r_q.arg;
                r_d.st    = S_WR_MSG;
            end
            S_WR_MSG: begin
                bus_wr    = 1'b1;
                bus_addr  = ADR_MSG;
                bus_wdata = DATA_W'(r_q.msg);
                r_d.st    = (r_q.limit == '0) ? S_FIN_RD : S_POLL_RD;
            end
            S_POLL_WAIT: begin
                if (tick_us) r_d.st = S_POLL_RD;
            end
            S_POLL_RD: begin
                bus_rd   = 1'b1;
                bus_addr = ADR_RESP;
                r_d.st   = S_POLL_CHK;
            end
            S_POLL_CHK: begin
                cnt_step = 1'b1;
                r_d.st   = (!dec_zero || cnt_last) ? S_FIN_RD : S_POLL_WAIT;
            end
            S_FIN_RD: begin
                bus_rd   = 1'b1;
                bus_addr = ADR_RESP;
                r_d.st   = S_FIN_CHK;
            end
            S_FIN_CHK: begin
                r_d.code  = bus_rdata[RESP_W-1:0];
                r_d.ok    = dec_ok;
                r_d.inval = dec_inval;
                r_d.to    = dec_zero;
                r_d.st    = (r_q.fetch && dec_ok) ? S_FET_RD : S_DONE;
            end
            S_FET_RD: begin
                bus_rd   = 1'b1;
                bus_addr = ADR_ARG;
                r_d.st   = S_FET_CHK;
            end
            S_FET_CHK: begin
                r_d.result = bus_rdata;
                r_d.st     = S_DONE;
            end
            S_DONE:  r_d.st = S_IDLE;
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy      = (r_q.st != S_IDLE);
    assign done      = (r_q.st == S_DONE);
    assign ok        = r_q.ok;
    assign err_inval = r_q.inval;
    assign timed_out = r_q.to;
    assign resp_code = r_q.code;
    assign result    = r_q.result;

    AST_ARG_BEFORE_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_MSG && r_q.has_arg)
            |-> $past(bus_wr && bus_addr == ADR_ARG)); // R2
    AST_POLL_PACED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_POLL_RD && $past(r_q.st) == S_POLL_WAIT) |-> $past(tick_us)); // R4
    AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd)); // R4
    AST_TIMEOUT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && timed_out) |-> (!ok && !err_inval && resp_code == '0)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_FETCH_ONLY_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADR_ARG) |-> ok); // R8
endmodule

// File: tb/sim_mbx_requester.sv
module sim_mbx_requester;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_msg = '0;
    logic        req_has_arg = 1'b0;
    logic [31:0] req_arg = '0;
    logic        req_fetch = 1'b0;
    logic [15:0] timeout_limit = '0;
    logic        tick_us = 1'b0;
    logic        busy, done, ok, err_inval, timed_out;
    logic [7:0]  resp_code;
    logic [31:0] result;
    logic        bus_wr, bus_rd;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;

    always #5 clk = ~clk;

    mbx_requester u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_msg(req_msg),
        .req_has_arg(req_has_arg), .req_arg(req_arg), .req_fetch(req_fetch),
        .timeout_limit(timeout_limit), .tick_us(tick_us), .busy(busy), .done(done),
        .ok(ok), .err_inval(err_inval), .timed_out(timed_out), .resp_code(resp_code),
        .result(result), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    int checks = 0;
    int fails  = 0;

    // Tick generator: one pulse every 5 cycles.
    logic [2:0] tdiv = '0;
    always @(posedge clk) begin
        tdiv    <= (tdiv == 3'd4) ? 3'd0 : tdiv + 3'd1;
        tick_us <= (tdiv == 3'd4);
    end

    // Register window and controller model.
    logic [31:0] fw_delay = '0;
    logic [31:0] fw_resp = '0;
    logic [31:0] fw_result = '0;
    logic [31:0] reg_arg = '0;
    logic [31:0] reg_resp = '0;
    logic [31:0] fw_cnt = '0;
    always @(posedge clk) begin
        if (bus_rd) bus_rdata <= (bus_addr == 2'd1) ? reg_arg :
                                 (bus_addr == 2'd2) ? reg_resp : 32'h0;
        if (bus_wr && bus_addr == 2'd1) reg_arg <= bus_wdata;
        if (bus_wr && bus_addr == 2'd0) begin
            reg_resp <= 32'h0;
            fw_cnt   <= fw_delay;
        end else if (tick_us && fw_cnt != 0) begin
            fw_cnt <= fw_cnt - 1;
            if (fw_cnt == 1) begin
                reg_resp <= fw_resp;
                reg_arg  <= fw_result;
            end
        end
    end

    // Bus monitor.
    logic        mon_clr = 1'b0;
    int          cyc = 0;
    int          arg_wr_n, msg_wr_n, resp_rd_n, arg_rd_n, tick_n, done_n, bad_bus_n;
    int          arg_wr_cyc, msg_wr_cyc;
    logic [31:0] arg_wr_val, msg_wr_val;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mon_clr) begin
            arg_wr_n <= 0; msg_wr_n <= 0; resp_rd_n <= 0; arg_rd_n <= 0;
            tick_n <= 0; done_n <= 0; bad_bus_n <= 0;
            arg_wr_cyc <= 0; msg_wr_cyc <= 0; arg_wr_val <= '0; msg_wr_val <= '0;
        end else begin
            if (bus_wr && bus_addr == 2'd1) begin
                arg_wr_n <= arg_wr_n + 1; arg_wr_cyc <= cyc; arg_wr_val <= bus_wdata;
            end
            if (bus_wr && bus_addr == 2'd0) begin
                msg_wr_n <= msg_wr_n + 1; msg_wr_cyc <= cyc; msg_wr_val <= bus_wdata;
            end
            if (bus_rd && bus_addr == 2'd2) resp_rd_n <= resp_rd_n + 1;
            if (bus_rd && bus_addr == 2'd1) arg_rd_n <= arg_rd_n + 1;
            if (tick_us && msg_wr_n != 0) tick_n <= tick_n + 1;
            if (done) done_n <= done_n + 1;
            if (!rst_n && (bus_wr || bus_rd)) bad_bus_n <= bad_bus_n + 1;
        end
    end

    task automatic check(input bit pass, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!pass) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #1500000;
        checks++; fails++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        finish_run();
    end

    typedef struct packed {
        logic [31:0] msg;
        logic        has_arg;
        logic [31:0] arg;
        logic        fetch;
        logic [15:0] limit;
        logic [31:0] delay;
        logic [31:0] resp;
        logic [31:0] fw;
        logic        exp_to;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{32'h0001_0042, 1'b1, 32'hDEAD_BEEF, 1'b0, 16'd50, 32'd3,  32'h0000_0001, 32'h0,         1'b0},
        '{32'h0000_0055, 1'b0, 32'h0,         1'b1, 16'd50, 32'd2,  32'h0000_0001, 32'hCAFE_0123, 1'b0},
        '{32'hFFFF_0013, 1'b1, 32'h1234_5678, 1'b0, 16'd50, 32'd1,  32'h0000_00FF, 32'h0,         1'b0},
        '{32'h0000_0021, 1'b1, 32'hA5A5_A5A5, 1'b1, 16'd50, 32'd4,  32'h0000_00FE, 32'h1111_2222, 1'b0},
        '{32'h0000_0030, 1'b0, 32'h0,         1'b1, 16'd50, 32'd2,  32'h0000_0007, 32'h0000_3333, 1'b0},
        '{32'h0000_0044, 1'b1, 32'h0BAD_F00D, 1'b1, 16'd4,  32'd40, 32'h0000_0001, 32'h0000_4444, 1'b1},
        '{32'h0000_0045, 1'b0, 32'h0,         1'b0, 16'd0,  32'd5,  32'h0000_0001, 32'h0,         1'b1},
        '{32'h0000_7FFF, 1'b0, 32'h0,         1'b1, 16'd50, 32'd3,  32'hABCD_0301, 32'h5555_6666, 1'b0}
    };

    task automatic issue(input vec_t v);
        @(negedge clk);
        fw_delay = v.delay; fw_resp = v.resp; fw_result = v.fw;
        req_msg = v.msg; req_has_arg = v.has_arg; req_arg = v.arg;
        req_fetch = v.fetch; timeout_limit = v.limit;
        mon_clr = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output bit got);
        got = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (done) begin got = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    initial begin
        bit got;
        mon_clr = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !bus_wr && !bus_rd, "R1 reset idle", {busy, done, bus_wr, bus_rd}, 0);
        check(!ok && !err_inval && !timed_out, "R1 reset flags", {ok, err_inval, timed_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !bus_wr && !bus_rd, "R1 after release", {busy, done, bus_wr, bus_rd}, 0);

        for (int k = 0; k < NV; k++) begin
            vec_t v;
            logic [7:0]  ecode;
            logic        eok, einv;
            logic [31:0] eres;
            v     = VECS[k];
            ecode = v.exp_to ? 8'h00 : v.resp[7:0];
            eok   = (ecode == 8'h01);
            einv  = (ecode == 8'hFE) || (ecode == 8'hFF);
            eres  = (v.fetch && eok) ? v.fw : 32'h0;
            issue(v);
            check(busy, "R9 busy after accept", busy, 1);
            wait_done(got);
            check(got, "R9 done reached", got, 1);
            check(resp_code == ecode, "R6 resp_code", resp_code, ecode);
            check(ok == eok && err_inval == einv, "R6 class", {ok, err_inval}, {eok, einv});
            check(timed_out == v.exp_to, "R7 timed_out", timed_out, v.exp_to);
            if (v.exp_to) check(!ok && !err_inval, "R7 no class on timeout", {ok, err_inval}, 0);
            check(result == eres, "R8 result", result, eres);
            check(arg_rd_n == ((v.fetch && eok) ? 1 : 0), "R8 fetch reads", arg_rd_n, (v.fetch && eok));
            check(msg_wr_n == 1, "R3 one msg write", msg_wr_n, 1);
            check(msg_wr_val == {16'h0, v.msg[15:0]}, "R3 msg masked", msg_wr_val, {16'h0, v.msg[15:0]});
            if (v.has_arg) begin
                check(arg_wr_n == 1 && arg_wr_val == v.arg, "R2 arg value", arg_wr_val, v.arg);
                check(arg_wr_cyc == msg_wr_cyc - 1, "R2 arg before msg", arg_wr_cyc, msg_wr_cyc - 1);
            end else begin
                check(arg_wr_n == 0, "R2 no arg write", arg_wr_n, 0);
            end
            if (v.exp_to)
                check(resp_rd_n == int'(v.limit) + 1, "R5 poll count", resp_rd_n, v.limit + 1);
            else
                check(resp_rd_n >= 2 && resp_rd_n <= tick_n + 2, "R4 poll pacing", resp_rd_n, tick_n + 2);
            @(negedge clk);
            check(!done && !busy, "R9 done one cycle", {done, busy}, 0);
            check(done_n == 1, "R9 done count", done_n, 1);
        end

        // R9: a request raised while busy is ignored.
        begin
            vec_t v;
            v = '{32'h0000_0101, 1'b0, 32'h0, 1'b0, 16'd50, 32'd3, 32'h1, 32'h0, 1'b0};
            issue(v);
            @(negedge clk);
            req_msg = 32'h0000_0202;
            req_valid = 1'b1;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
            wait_done(got);
            @(negedge clk);
            check(msg_wr_n == 1, "R9 busy request ignored", msg_wr_n, 1);
            check(msg_wr_val == 32'h0000_0101, "R9 first message kept", msg_wr_val, 32'h101);
            repeat (4) @(negedge clk);
            check(!busy && msg_wr_n == 1, "R9 no late start", {busy, msg_wr_n[0]}, {1'b0, 1'b1});
        end

        // R1: reset in the middle of polling.
        begin
            vec_t v;
            v = '{32'h0000_0077, 1'b1, 32'h7777_0000, 1'b0, 16'd200, 32'd100, 32'h1, 32'h0, 1'b0};
            issue(v);
            repeat (12) @(negedge clk);
            check(busy, "R1 busy mid poll", busy, 1);
            rst_n = 1'b0;
            @(negedge clk);
            check(!busy && !bus_wr && !bus_rd && !done, "R1 mid reset idle", {busy, bus_wr, bus_rd, done}, 0);
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            repeat (20) @(negedge clk);
            check(!busy && !bus_rd && !bus_wr, "R1 stays idle", {busy, bus_rd, bus_wr}, 0);
            check(bad_bus_n == 0, "R1 no access in reset", bad_bus_n, 0);
        end

        finish_run();
    end
endmodule